// File: doc/BRIEF.md
# Scaled Timestamp Counter

This block keeps a free-running 64-bit timestamp that downstream timers consume directly from a parallel output bus instead of counting a clock themselves. Inside, the count lives in an 88-bit fixed-point accumulator: 64 integer bits and 24 fraction bits. On each qualified input tick the accumulator grows by exactly one integer unit. When scaling is turned on, it grows by a programmable 8.24 increment instead. Only the integer part is visible.

Software reaches the block over a simple 32-bit register bus with two frame selects, each frame spanning 4 KB. The control frame holds the control word, the count as two writable halves, the increment register with its alias, an ID word and a block of identification bytes. The status frame gives a read-only view of the count and carries its own identification bytes. Reads are combinational. Writes take effect at the clock edge.

Top module: `tsc_counter`

## Requirements
- R1: After reset the count is zero, the control word reads 0x0, and the increment register reads 0x01000000 (1.0 in 8.24 format).
- R2: A write to control offset 0x0 stores bits [4:0] and reads them back. These bits are: bit0 run, bit1 halt-on-debug, bit2 scaling on, bit3 interrupt mask, bit4 error-response disable. Bits [31:5] read as zero and ignore writes.
- R3: With run set and scaling off, each tick raises the count by exactly 1. A cycle without a tick leaves the count unchanged.
- R4: With run and scaling both set, each tick adds the 32-bit increment register, zero-extended, to the 88-bit accumulator. The count is bits [87:24] of that accumulator.
- R5: With run clear, the count holds its value whatever the tick input does.
- R6: A write to control offset 0x8 replaces count bits [31:0]; a write to 0xC replaces bits [63:32]. The other half is kept, and the 24 fraction bits are cleared.
- R7: The increment register is read and written at control offset 0x10 and also at 0xD0. Offset 0xD4 reads zero and ignores writes. Offset 0x4 always reads zero.
- R8: Control offset 0x1C reads 0x00020001: the scaling-supported field [3:0] equals 1, the selected-clock field [18:17] equals 1, and all other bits are zero.
- R9: Both frames return identification bytes at offsets 0xFD0 to 0xFFC, in order: 04 00 00 00, then xx B0 0B 00, then 0D F0 05 B1. The byte xx is BA in the control frame and BB in the status frame.
- R10: Status offset 0x0 reads count [31:0] and offset 0x4 reads count [63:32]. Writes to the status frame change nothing.
- R11: Reads of unmapped offsets in either frame return zero. Writes to unmapped or read-only control offsets leave every register unchanged.
- R12: In a cycle that carries any control-frame write, the tick is dropped and the count does not advance from it.
- R13: The output bus `count_o` always equals the count that the register reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-advance strobe, one per timestamp tick |
| ctl_sel | input | 1 | Selects the control frame for this access |
| sts_sel | input | 1 | Selects the status frame for this access |
| wr_en | input | 1 | Write strobe (read when low) |
| addr | input | 12 | Byte offset within the selected frame, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| count_o | output | 64 | Current visible count for downstream timers |

## Verification
A tick and a control-frame write can arrive in the same cycle. The write may target the count halves, the increment register or the control word. The random phase asserts tick on most cycles while it also issues writes, so these collisions happen often. Directed cases add a tick to writes of the increment register and of a count half. The outcome is judged against a bench model in which the write wins and the tick is lost. One case proves the loss at the ports: a tick driven together with a write to the increment register leaves the count unchanged.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   localparam int unsigned WORD_IDX_W = 10;

   localparam logic [WORD_IDX_W-1:0] W_CTRL    = 10'h000;
   localparam logic [WORD_IDX_W-1:0] W_STAT    = 10'h001;
   localparam logic [WORD_IDX_W-1:0] W_CNT_LO  = 10'h002;
   localparam logic [WORD_IDX_W-1:0] W_CNT_HI  = 10'h003;
   localparam logic [WORD_IDX_W-1:0] W_INC     = 10'h004;
   localparam logic [WORD_IDX_W-1:0] W_IDENT   = 10'h007;
   localparam logic [WORD_IDX_W-1:0] W_INC_ALT = 10'h034;
   localparam logic [WORD_IDX_W-1:0] W_INC_2ND = 10'h035;
   localparam logic [WORD_IDX_W-1:0] W_ID_BASE = 10'h3F4;
   localparam int unsigned           ID_WORDS  = 12;

   localparam logic [31:0] IDENT_VALUE = 32'h0002_0001;

   typedef struct packed {
      logic err_off;
      logic irq_mask;
      logic scale_on;
      logic dbg_halt;
      logic run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

   function automatic logic [7:0] id_byte(input int unsigned idx, input bit status_frame);
      logic [7:0] b;
      case (idx)
         0:       b = 8'h04;
         4:       b = status_frame ? 8'hBB : 8'hBA;
         5:       b = 8'hB0;
         6:       b = 8'h0B;
         8:       b = 8'h0D;
         9:       b = 8'hF0;
         10:      b = 8'h05;
         11:      b = 8'hB1;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
   import tsc_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SCALE_W = 32,
   parameter int unsigned FRAC_W  = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_wr,
   input  logic [WORD_IDX_W-1:0] widx,
   input  logic [DATA_W-1:0]     wdata,
   output ctrl_t                 ctrl_q,
   output logic [SCALE_W-1:0]    inc_q,
   output logic                  wr_lo,
   output logic                  wr_hi
);

   localparam logic [SCALE_W-1:0] INC_RESET = SCALE_W'(1) << FRAC_W;

   logic hit_ctrl;
   logic hit_inc;

   always_comb begin
      hit_ctrl = ctl_wr && (widx == W_CTRL);
      hit_inc  = ctl_wr && ((widx == W_INC) || (widx == W_INC_ALT));
      wr_lo    = ctl_wr && (widx == W_CNT_LO);
      wr_hi    = ctl_wr && (widx == W_CNT_HI);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (hit_ctrl) begin
         ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_q <= INC_RESET;
      end else if (hit_inc) begin
         inc_q <= wdata[SCALE_W-1:0];
      end
   end

endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned FRAC_W  = 24,
   parameter int unsigned SCALE_W = 32,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  logic               scale_on,
   input  logic [SCALE_W-1:0] inc,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic [DATA_W-1:0]  wdata,
   output logic [CNT_W-1:0]   count
);

   localparam int unsigned ACC_W  = CNT_W + FRAC_W;
   localparam int unsigned HALF_W = CNT_W / 2;
   localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] step;
   logic [CNT_W-1:0] cur;
   logic [CNT_W-1:0] patched;

   assign cur   = acc_q[ACC_W-1:FRAC_W];
   assign count = cur;

   generate
      if (SCALE_W >= ACC_W) begin : g_step_wide
         always_comb step = scale_on ? inc[ACC_W-1:0] : UNIT;
      end else begin : g_step_ext
         always_comb step = scale_on ? {{(ACC_W-SCALE_W){1'b0}}, inc} : UNIT;
      end
   endgenerate

   always_comb begin
      patched = cur;
      if (wr_lo) patched[HALF_W-1:0]     = wdata[HALF_W-1:0];
      if (wr_hi) patched[CNT_W-1:HALF_W] = wdata[HALF_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (wr_lo || wr_hi) begin
         acc_q <= {patched, {FRAC_W{1'b0}}};
      end else if (adv) begin
         acc_q <= acc_q + step;
      end
   end

endmodule

// File: rtl/tsc_rdmux.sv
module tsc_rdmux
   import tsc_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SCALE_W = 32
) (
   input  logic                  ctl_sel,
   input  logic                  sts_sel,
   input  logic [WORD_IDX_W-1:0] widx,
   input  ctrl_t                 ctrl_q,
   input  logic [SCALE_W-1:0]    inc_q,
   input  logic [CNT_W-1:0]      count,
   output logic [DATA_W-1:0]     rdata
);

   localparam int unsigned HALF_W = CNT_W / 2;

   logic [DATA_W-1:0] ctl_id [ID_WORDS];
   logic [DATA_W-1:0] sts_id [ID_WORDS];

   genvar gi;
   generate
      for (gi = 0; gi < ID_WORDS; gi++) begin : g_id
         assign ctl_id[gi] = DATA_W'(id_byte(gi, 1'b0));
         assign sts_id[gi] = DATA_W'(id_byte(gi, 1'b1));
      end
   endgenerate

   logic                  in_id;
   logic [WORD_IDX_W-1:0] id_off;
   logic [DATA_W-1:0]     ctl_rd;
   logic [DATA_W-1:0]     sts_rd;

   always_comb begin
      id_off = widx - W_ID_BASE;
      in_id  = (widx >= W_ID_BASE);
   end

   always_comb begin
      ctl_rd = '0;
      if (in_id) begin
         ctl_rd = ctl_id[id_off[3:0]];
      end else begin
         case (widx)
            W_CTRL:             ctl_rd = DATA_W'(ctrl_q);
            W_CNT_LO:           ctl_rd = DATA_W'(count[HALF_W-1:0]);
            W_CNT_HI:           ctl_rd = DATA_W'(count[CNT_W-1:HALF_W]);
            W_INC, W_INC_ALT:   ctl_rd = DATA_W'(inc_q);
            W_IDENT:            ctl_rd = IDENT_VALUE;
            default:            ctl_rd = '0;
         endcase
      end
   end

   always_comb begin
      sts_rd = '0;
      if (in_id) begin
         sts_rd = sts_id[id_off[3:0]];
      end else begin
         case (widx)
            10'h000: sts_rd = DATA_W'(count[HALF_W-1:0]);
            10'h001: sts_rd = DATA_W'(count[CNT_W-1:HALF_W]);
            default: sts_rd = '0;
         endcase
      end
   end

   always_comb begin
      if (ctl_sel)      rdata = ctl_rd;
      else if (sts_sel) rdata = sts_rd;
      else              rdata = '0;
   end

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter
   import tsc_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned FRAC_W  = 24,
   parameter int unsigned SCALE_W = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ctl_sel,
   input  logic              sts_sel,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count_o
);

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
         $error("count width must be twice the bus width");
      end
      if (ADDR_W != WORD_IDX_W + 2) begin : g_bad_addr
         $error("address width must cover one 4 KB frame");
      end
      if (SCALE_W > DATA_W || FRAC_W >= SCALE_W) begin : g_bad_scale
         $error("increment must fit the bus and exceed the fraction");
      end
   endgenerate

   logic [WORD_IDX_W-1:0] widx;
   logic                  ctl_wr;
   ctrl_t                 ctrl_q;
   logic [SCALE_W-1:0]    inc_q;
   logic                  wr_lo;
   logic                  wr_hi;
   logic                  adv;
   logic                  run_q;
   logic                  scale_q;

   assign widx    = addr[ADDR_W-1:2];
   assign ctl_wr  = ctl_sel && wr_en;
   assign run_q   = ctrl_q.run;
   assign scale_q = ctrl_q.scale_on;
   assign adv     = tick && run_q && !ctl_wr;

   tsc_regs #(
      .DATA_W (DATA_W),
      .SCALE_W(SCALE_W),
      .FRAC_W (FRAC_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl_wr(ctl_wr),
      .widx  (widx),
      .wdata (wdata),
      .ctrl_q(ctrl_q),
      .inc_q (inc_q),
      .wr_lo (wr_lo),
      .wr_hi (wr_hi)
   );

   tsc_accum #(
      .CNT_W  (CNT_W),
      .FRAC_W (FRAC_W),
      .SCALE_W(SCALE_W),
      .DATA_W (DATA_W)
   ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .scale_on(scale_q),
      .inc     (inc_q),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wdata   (wdata),
      .count   (count_o)
   );

   tsc_rdmux #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .SCALE_W(SCALE_W)
   ) u_rdmux (
      .ctl_sel(ctl_sel),
      .sts_sel(sts_sel),
      .widx   (widx),
      .ctrl_q (ctrl_q),
      .inc_q  (inc_q),
      .count  (count_o),
      .rdata  (rdata)
   );

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              ctl_sel,
   input logic              sts_sel,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [CNT_W-1:0]  count_o,
   input logic              run_q,
   input logic              scale_q
);

   localparam int unsigned HALF_W = CNT_W / 2;

   logic cw;
   logic [ADDR_W-3:0] wi;
   assign cw = ctl_sel && wr_en;
   assign wi = addr[ADDR_W-1:2];

   // R5: stopped counter holds
   a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cw) |=> $stable(count_o));

   // R3: unit step per tick
   a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !scale_q && tick && !cw) |=> (count_o == $past(count_o) + 1'b1));

   // R6: low half write
   a_r6_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      (cw && wi == 'h2) |=> (count_o[HALF_W-1:0] == $past(wdata[HALF_W-1:0]) &&
                             count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W])));

   // R6: high half write
   a_r6_high_half: assert property (@(posedge clk) disable iff (!rst_n)
      (cw && wi == 'h3) |=> (count_o[CNT_W-1:HALF_W] == $past(wdata[HALF_W-1:0]) &&
                             count_o[HALF_W-1:0] == $past(count_o[HALF_W-1:0])));

   // R12: other control writes swallow the tick
   a_r12_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (cw && wi != 'h2 && wi != 'h3) |=> $stable(count_o));

   // R10: status-frame writes change nothing
   a_r10_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_sel && !ctl_sel && wr_en && !tick) |=> $stable(count_o));

endmodule

bind tsc_counter tsc_checker #(
   .CNT_W (CNT_W),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) u_tsc_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .ctl_sel(ctl_sel),
   .sts_sel(sts_sel),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .count_o(count_o),
   .run_q  (run_q),
   .scale_q(scale_q)
);

// File: tb/tsc_counter_bench.sv
module tsc_counter_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        ctl_sel = 1'b0;
   logic        sts_sel = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [63:0] count_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [87:0] m_acc = '0;
   logic [4:0]  m_ctrl = '0;
   logic [31:0] m_inc = 32'h0100_0000;

   always #(CLK_P/2) clk = ~clk;

   tsc_counter u_tsc_counter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_sel(ctl_sel), .sts_sel(sts_sel),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .count_o(count_o)
   );

   function automatic logic [63:0] m_cnt();
      return m_acc[87:24];
   endfunction

   function automatic logic [7:0] exp_id(input int idx, input bit sts);
      logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'hBA, 8'hB0, 8'h0B, 8'h00,
                             8'h0D, 8'hF0, 8'h05, 8'hB1};
      if (idx == 4 && sts) return 8'hBB;
      return t[idx];
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model(input bit tk, input bit cw, input logic [11:0] a, input logic [31:0] d);
      logic [63:0] c;
      c = m_cnt();
      if (cw) begin
         case (a)
            12'h000: m_ctrl = d[4:0];
            12'h008: begin c[31:0] = d;  m_acc = {c, 24'h0}; end
            12'h00C: begin c[63:32] = d; m_acc = {c, 24'h0}; end
            12'h010, 12'h0D0: m_inc = d;
            default: ;
         endcase
      end else if (tk && m_ctrl[0]) begin
         m_acc = m_acc + (m_ctrl[2] ? {56'h0, m_inc} : (88'h1 << 24));
      end
   endtask

   // drive one cycle from a negedge, compare count at the following negedge
   task automatic step(input string req, input bit tk, input bit cw, input bit sw,
                       input logic [11:0] a, input logic [31:0] d);
      tick = tk; ctl_sel = cw; sts_sel = sw; wr_en = cw | sw; addr = a; wdata = d;
      @(posedge clk);
      model(tk, cw, a, d);
      @(negedge clk);
      tick = 0; ctl_sel = 0; sts_sel = 0; wr_en = 0;
      chk(req, count_o, m_cnt());
   endtask

   task automatic rd(input bit sts, input logic [11:0] a, output logic [31:0] v);
      ctl_sel = !sts; sts_sel = sts; wr_en = 0; addr = a;
      #1 v = rdata;
      ctl_sel = 0; sts_sel = 0;
   endtask

   task automatic rd_chk(input string req, input bit sts, input logic [11:0] a,
                         input logic [31:0] exp);
      logic [31:0] v;
      rd(sts, a, v);
      chk(req, {32'h0, v}, {32'h0, exp});
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 count", count_o, 64'h0);
      rd_chk("R1 ctrl", 0, 12'h000, 32'h0);
      rd_chk("R1 inc", 0, 12'h010, 32'h0100_0000);

      // R2 control storage
      step("R2", 0, 1, 0, 12'h000, 32'hFFFF_FFFF);
      rd_chk("R2 ctrl mask", 0, 12'h000, 32'h0000_001F);
      step("R2", 0, 1, 0, 12'h000, 32'h0000_0012);
      rd_chk("R2 ctrl value", 0, 12'h000, 32'h0000_0012);
      step("R2", 0, 1, 0, 12'h000, 32'h0);

      // R7 increment alias, zero registers
      step("R7", 0, 1, 0, 12'h0D0, 32'h0200_0000);
      rd_chk("R7 alias read", 0, 12'h010, 32'h0200_0000);
      step("R7", 0, 1, 0, 12'h0D4, 32'hDEAD_BEEF);
      rd_chk("R7 second inc", 0, 12'h0D4, 32'h0);
      rd_chk("R7 inc kept", 0, 12'h0D0, 32'h0200_0000);
      rd_chk("R7 status word", 0, 12'h004, 32'h0);
      step("R7", 0, 1, 0, 12'h010, 32'h0100_0000);

      // R8 ID, R9 identification bytes
      rd_chk("R8 ident", 0, 12'h01C, 32'h0002_0001);
      for (int i = 0; i < 12; i++) begin
         rd_chk("R9 ctl id", 0, 12'hFD0 + 12'(4 * i), {24'h0, exp_id(i, 0)});
         rd_chk("R9 sts id", 1, 12'hFD0 + 12'(4 * i), {24'h0, exp_id(i, 1)});
      end

      // R5 stopped holds
      repeat (5) step("R5", 1, 0, 0, 12'h0, 32'h0);
      chk("R5 still zero", count_o, 64'h0);

      // R3 unit steps with gaps
      step("R3", 0, 1, 0, 12'h000, 32'h1);
      for (int i = 0; i < 10; i++) step("R3", 1, 0, 0, 12'h0, 32'h0);
      step("R3", 0, 0, 0, 12'h0, 32'h0);
      chk("R3 ten ticks", count_o, 64'd10);

      // R6 half writes, carry across halves
      step("R6", 0, 1, 0, 12'h008, 32'hFFFF_FFFF);
      chk("R6 lo write", count_o, 64'h0000_0000_FFFF_FFFF);
      step("R6", 1, 0, 0, 12'h0, 32'h0);
      chk("R6 carry", count_o, 64'h0000_0001_0000_0000);
      step("R6", 1, 1, 0, 12'h00C, 32'h1234_5678);
      chk("R6 hi write keeps lo", count_o, 64'h1234_5678_0000_0000);

      // R13 output matches reads
      rd(0, 12'h008, v); chk("R13 lo", {32'h0, v}, {32'h0, count_o[31:0]});
      rd(0, 12'h00C, v); chk("R13 hi", {32'h0, v}, {32'h0, count_o[63:32]});
      // R10 status view and read-only
      rd_chk("R10 sts lo", 1, 12'h000, m_cnt()[31:0]);
      rd_chk("R10 sts hi", 1, 12'h004, m_cnt()[63:32]);
      step("R10", 0, 0, 1, 12'h000, 32'hAAAA_AAAA);
      step("R10", 0, 0, 1, 12'h004, 32'h5555_5555);
      chk("R10 unchanged", count_o, 64'h1234_5678_0000_0000);

      // R4 half-unit scaling, fraction cleared by count write
      step("R4", 0, 1, 0, 12'h010, 32'h0080_0000);
      step("R4", 0, 1, 0, 12'h000, 32'h5);
      step("R4", 0, 1, 0, 12'h00C, 32'h0);
      step("R4", 0, 1, 0, 12'h008, 32'h0);
      repeat (3) step("R4", 1, 0, 0, 12'h0, 32'h0);
      chk("R4 1.5 -> 1", count_o, 64'd1);
      step("R6", 0, 1, 0, 12'h008, 32'h7);
      step("R4", 1, 0, 0, 12'h0, 32'h0);
      chk("R6 fraction cleared", count_o, 64'd7);
      step("R4", 1, 0, 0, 12'h0, 32'h0);
      chk("R4 7.5+0.5", count_o, 64'd8);
      step("R4", 0, 1, 0, 12'h010, 32'hFFFF_FFFF);
      step("R4", 1, 0, 0, 12'h0, 32'h0);
      chk("R4 large inc", count_o, 64'd8 + 64'd255);

      // R12 collision: tick with increment write
      step("R12", 1, 1, 0, 12'h010, 32'h0100_0000);
      chk("R12 tick dropped", count_o, 64'd263);

      // R11 unmapped
      rd_chk("R11 ctl unmapped", 0, 12'h020, 32'h0);
      rd_chk("R11 sts unmapped", 1, 12'h008, 32'h0);
      step("R11", 0, 1, 0, 12'h800, 32'hFFFF_FFFF);
      step("R11", 0, 1, 0, 12'h01C, 32'hFFFF_FFFF);
      rd_chk("R11 ctrl kept", 0, 12'h000, 32'h5);
      rd_chk("R11 inc kept", 0, 12'h010, 32'h0100_0000);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int unsigned r = $urandom_range(0, 99);
         bit tk = ($urandom_range(0, 9) < 7);
         logic [11:0] a;
         logic [31:0] d = $urandom();
         if (r < 70) step("R4 random", tk, 0, 0, 12'h0, 32'h0);
         else begin
            case ($urandom_range(0, 7))
               0: begin a = 12'h000; d = {27'h0, 1'b1, d[3:0]}; end
               1: a = 12'h008;
               2: a = 12'h00C;
               3: begin a = 12'h010; d = {8'h0, d[23:0]} | 32'h0010_0000; end
               4: a = 12'h0D0;
               5: a = 12'h0D4;
               6: a = 12'h900;
               default: a = 12'h000;
            endcase
            if ($urandom_range(0, 4) == 0) step("R10 random", 0, 0, 1, a, d);
            else step("R12 random", tk, 1, 0, a, d);
         end
         if (i % 100 == 0) begin
            rd_chk("R13 random lo", 0, 12'h008, m_cnt()[31:0]);
            rd_chk("R10 random hi", 1, 12'h004, m_cnt()[63:32]);
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule